// File: doc/BRIEF.md
# Register Scoreboard with Read/Write Precedence

This block is the central scoreboard for a small register file that three functional units share: a divider, a multiplier and an adder. It holds no register data. It only decides when a unit may begin, when a unit may put its result on the shared result bus, and when the issue stage has to stall. Each register has a producer tag, a reader tag and a precedence bit. The producer tag names the unit that will write the register next. The reader tag names a unit that has been issued but has not yet read the register. The precedence bit says whether that pending read must come before the next write.

Issue requests carry the unit tag, two source register numbers and a destination register number. A source whose producer is still running is not read from the register file. The consumer instead waits for that producer's broadcast, so no reader tag is placed on it. A source with no producer gets the issuing unit's reader tag, which blocks any later writer of that register. A unit reports when it begins reading its operands. That report clears its reader tags, hands precedence to the write side and so releases a waiting writer. A unit that has begun may ask to broadcast. Only one grant is given per cycle.

Top module: `sb_scoreboard`

## Requirements
- R1: A synchronous active-low reset empties every producer tag, reader tag and unit slot. While reset is low and after it is released, freeze is low, no start grant is given and no broadcast grant is given, even with result requests raised.
- R2: Unit tags are 1 = divide, 2 = multiply and 3 = add, with 0 meaning empty. Bit k of start_grant, rd_begin, res_req and bcast_grant belongs to tag k+1. An accepted issue whose sources and destination are free raises that unit's start grant in the next cycle.
- R3: A source whose producer is still pending becomes an operand wait on that producer's tag. The consumer's start grant rises in the cycle after the producer's broadcast. No reader tag is placed on that register, so a new writer to it is accepted and granted a start while the consumer is still waiting.
- R4: A writer whose destination carries another unit's reader tag with read precedence is accepted at issue but gets no start grant. The grant comes only in the cycle after that reader reports rd_begin.
- R5: An rd_begin report clears the reporting unit's reader tags and sets write precedence. After that, an issue that reads those registers is no longer frozen.
- R6: freeze rises in the same cycle as issue_valid when the requested unit is busy, when the destination has a pending producer, or when a source already carries a reader tag. A frozen request is not accepted.
- R7: bcast_grant is at most one-hot. It goes only to a unit that has begun and is raising res_req, and the lowest tag wins. bcast_tag gives the tag of the granted unit.
- R8: A broadcast empties the producer tag of the broadcasting unit's destination and frees that unit. A later issue that writes the same register, or that uses that unit, is accepted.
- R9: An issue in the same cycle as a broadcast sees the broadcast's effect at once. It may use the unit that is broadcasting, and it treats that unit's destination as available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An instruction is offered for issue this cycle |
| issue_unit | input | 2 | Tag of the unit the instruction targets |
| issue_dst | input | 3 | Destination register number |
| issue_src_a | input | 3 | First source register number |
| issue_src_b | input | 3 | Second source register number |
| rd_begin | input | 3 | Per unit: operands are being read this cycle |
| res_req | input | 3 | Per unit: result is ready for broadcast |
| start_grant | output | 3 | Per unit: permission to begin |
| bcast_grant | output | 3 | Per unit: permission to broadcast this cycle |
| bcast_tag | output | 2 | Tag of the unit granted the broadcast, 0 if none |
| freeze | output | 1 | Issue stage must hold the offered instruction |

## Verification
The assertions assume well-behaved unit stubs. A unit raises rd_begin only in a cycle where its start grant is high, and it raises res_req only after it has begun. The assertions also assume that a unit drops its request once the grant has been given. The directed tasks drive rd_begin and res_req by hand and never report a read without a live grant. A unit is never re-issued until its broadcast has been granted, except for the same-cycle case that R9 describes. Every task drains the units back to idle, so the next scenario starts from an empty table.

// File: rtl/sb_pkg.sv
// Package: shared defaults and encodings for the register scoreboard.
// Assumes tag value 0 is reserved for "empty"; unit tags run 1..NUNITS.
package sb_pkg;
    localparam int SB_NREGS  = 8;
    localparam int SB_NUNITS = 3;

    // Precedence of the pending access on a register.
    typedef enum logic {
        PREC_W = 1'b0,   // the next write may proceed
        PREC_R = 1'b1    // a pending read must happen before any write
    } prec_e;
endpackage

// File: rtl/sb_regtable.sv
// Per-register tag table: producer tag, reader tag and precedence bit.
// Assumes the top only places a reader tag on a register whose reader tag
// is currently empty, and only sets a producer tag on a free register.
module sb_regtable
    import sb_pkg::*;
#(
    parameter int NREGS  = SB_NREGS,
    parameter int NUNITS = SB_NUNITS,
    localparam int TW = $clog2(NUNITS + 1),
    localparam int AW = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_acc,
    input  logic [TW-1:0] iss_unit,
    input  logic [AW-1:0] iss_dst,
    input  logic [AW-1:0] iss_src_a,
    input  logic [AW-1:0] iss_src_b,
    input  logic          src_a_rd,
    input  logic          src_b_rd,
    input  logic [NUNITS-1:0] rdb,
    input  logic          bc_valid,
    input  logic [TW-1:0] bc_tag,
    output logic [TW-1:0] wtag_o [NREGS],
    output logic [TW-1:0] rtag_o [NREGS],
    output prec_e         prec_o [NREGS]
);
    logic [NUNITS:0] rdb_ext;
    assign rdb_ext = {rdb, 1'b0};

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        logic place_rd;
        assign place_rd = iss_acc &&
                          ((src_a_rd && iss_src_a == AW'(r)) ||
                           (src_b_rd && iss_src_b == AW'(r)));

        // Producer tag: cleared by its broadcast, set by an accepted issue.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wtag_o[r] <= '0;
            end else begin
                if (bc_valid && wtag_o[r] == bc_tag) wtag_o[r] <= '0;
                if (iss_acc && iss_dst == AW'(r))    wtag_o[r] <= iss_unit;
            end
        end

        // Reader tag and precedence: released by rd_begin, set at issue.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rtag_o[r] <= '0;
                prec_o[r] <= PREC_W;
            end else begin
                if (rtag_o[r] != '0 && rdb_ext[rtag_o[r]]) begin
                    rtag_o[r] <= '0;
                    prec_o[r] <= PREC_W;
                end
                if (place_rd) begin
                    rtag_o[r] <= iss_unit;
                    prec_o[r] <= PREC_R;
                end
            end
        end

        // R5: the reader beginning hands precedence to the write side.
        a_r5_prec_release: assert property (@(posedge clk) disable iff (!rst_n)
            (rtag_o[r] != '0 && rdb_ext[rtag_o[r]]) |=> (prec_o[r] == PREC_W && rtag_o[r] == '0));
    end
endmodule

// File: rtl/sb_unitslot.sv
// One functional unit's slot: busy/started state and two operand waits.
// Assumes the unit raises rdb only while its start grant is high and
// raises res_req only after it has begun.
module sb_unitslot
    import sb_pkg::*;
#(
    parameter int NREGS  = SB_NREGS,
    parameter int NUNITS = SB_NUNITS,
    parameter int UNIT   = 1,
    localparam int TW = $clog2(NUNITS + 1),
    localparam int AW = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] ld_opa,
    input  logic [TW-1:0] ld_opb,
    input  logic [AW-1:0] ld_dst,
    input  logic          rdb,
    input  logic          res_req,
    input  logic          bc_valid,
    input  logic [TW-1:0] bc_tag,
    input  logic          bc_mine,
    input  logic [TW-1:0] rtag_dst,
    input  prec_e         prec_dst,
    output logic          busy,
    output logic          start_grant,
    output logic          elig,
    output logic [AW-1:0] dst
);
    logic          started;
    logic [TW-1:0] opa, opb;

    // Start permission: operands present and no foreign read ahead of the write.
    always_comb begin
        start_grant = busy && !started && opa == '0 && opb == '0 &&
                      (prec_dst == PREC_W || rtag_dst == TW'(UNIT));
        elig = busy && started && res_req;
    end

    // Slot state: released by own broadcast, operand waits cleared by others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            started <= 1'b0;
            opa     <= '0;
            opb     <= '0;
            dst     <= '0;
        end else begin
            if (bc_mine) begin
                busy    <= 1'b0;
                started <= 1'b0;
            end
            if (rdb && start_grant) started <= 1'b1;
            if (bc_valid && opa == bc_tag) opa <= '0;
            if (bc_valid && opb == bc_tag) opb <= '0;
            if (load) begin
                busy    <= 1'b1;
                started <= 1'b0;
                opa     <= ld_opa;
                opb     <= ld_opb;
                dst     <= ld_dst;
            end
        end
    end

    // R4: a unit reports reading its operands only under a start grant.
    a_r4_read_under_grant: assert property (@(posedge clk) disable iff (!rst_n)
        rdb |-> start_grant);
    // R7: the arbiter grants only a begun unit that is requesting.
    a_r7_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        bc_mine |-> (busy && started && res_req));
    // R8: a granted broadcast leaves the slot not started.
    a_r8_slot_release: assert property (@(posedge clk) disable iff (!rst_n)
        bc_mine |=> !started);
endmodule

// File: rtl/sb_bcast_arb.sv
// Fixed-priority result-bus arbiter: the lowest unit tag wins.
// Assumes eligibility is already qualified by each slot.
module sb_bcast_arb
    import sb_pkg::*;
#(
    parameter int NUNITS = SB_NUNITS,
    localparam int TW = $clog2(NUNITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUNITS-1:0] elig,
    output logic [NUNITS-1:0] grant,
    output logic              valid,
    output logic [TW-1:0]     tag
);
    // Scan from tag 1 upward; the first eligible unit takes the bus.
    always_comb begin
        grant = '0;
        tag   = '0;
        for (int i = 0; i < NUNITS; i++) begin
            if (elig[i] && grant == '0) begin
                grant[i] = 1'b1;
                tag      = TW'(i + 1);
            end
        end
        valid = grant != '0;
    end

    // R7: never more than one unit on the result bus.
    a_r7_bus_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    for (genvar g = 1; g < NUNITS; g++) begin : g_prio
        // R7: a granted unit has no eligible lower-tag competitor.
        a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
            grant[g] |-> (elig[g-1:0] == '0));
    end
endmodule

// File: rtl/sb_scoreboard.sv
// Top: issue check, register tag table, unit slots and broadcast arbiter.
// Assumes one issue request per cycle and well-behaved unit stubs.
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter int NREGS  = SB_NREGS,
    parameter int NUNITS = SB_NUNITS,
    localparam int TW = $clog2(NUNITS + 1),
    localparam int AW = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [TW-1:0]     issue_unit,
    input  logic [AW-1:0]     issue_dst,
    input  logic [AW-1:0]     issue_src_a,
    input  logic [AW-1:0]     issue_src_b,
    input  logic [NUNITS-1:0] rd_begin,
    input  logic [NUNITS-1:0] res_req,
    output logic [NUNITS-1:0] start_grant,
    output logic [NUNITS-1:0] bcast_grant,
    output logic [TW-1:0]     bcast_tag,
    output logic              freeze
);
    logic [TW-1:0]     wtag [NREGS];
    logic [TW-1:0]     rtag [NREGS];
    prec_e             prec [NREGS];
    logic [NUNITS-1:0] busy_v, elig_v;
    logic [AW-1:0]     dst_v [NUNITS];
    logic              bc_valid;
    logic [NUNITS:0]   busy_ext, grant_ext;
    logic [TW-1:0]     wa_eff, wb_eff, wd_eff;
    logic              unit_ok, unit_busy, conflict, iss_acc;

    // Producer tag of a register as seen after this cycle's broadcast.
    function automatic logic [TW-1:0] eff_wtag(input logic [TW-1:0] t,
                                               input logic v,
                                               input logic [TW-1:0] b);
        return (v && t == b) ? '0 : t;
    endfunction

    // Issue check: unit free, destination unclaimed, no reader tag on a source.
    always_comb begin
        busy_ext  = {busy_v, 1'b0};
        grant_ext = {bcast_grant, 1'b0};
        unit_ok   = issue_unit != '0 && int'(issue_unit) <= NUNITS;
        unit_busy = busy_ext[issue_unit] && !grant_ext[issue_unit];
        wa_eff    = eff_wtag(wtag[issue_src_a], bc_valid, bcast_tag);
        wb_eff    = eff_wtag(wtag[issue_src_b], bc_valid, bcast_tag);
        wd_eff    = eff_wtag(wtag[issue_dst],   bc_valid, bcast_tag);
        conflict  = !unit_ok || unit_busy || wd_eff != '0 ||
                    rtag[issue_src_a] != '0 || rtag[issue_src_b] != '0;
        freeze    = rst_n && issue_valid && conflict;
        iss_acc   = rst_n && issue_valid && !conflict;
    end

    sb_regtable #(.NREGS(NREGS), .NUNITS(NUNITS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .iss_acc  (iss_acc),
        .iss_unit (issue_unit),
        .iss_dst  (issue_dst),
        .iss_src_a(issue_src_a),
        .iss_src_b(issue_src_b),
        .src_a_rd (wa_eff == '0),
        .src_b_rd (wb_eff == '0),
        .rdb      (rd_begin),
        .bc_valid (bc_valid),
        .bc_tag   (bcast_tag),
        .wtag_o   (wtag),
        .rtag_o   (rtag),
        .prec_o   (prec)
    );

    for (genvar u = 0; u < NUNITS; u++) begin : g_unit
        sb_unitslot #(.NREGS(NREGS), .NUNITS(NUNITS), .UNIT(u + 1)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (iss_acc && issue_unit == TW'(u + 1)),
            .ld_opa     (wa_eff),
            .ld_opb     (wb_eff),
            .ld_dst     (issue_dst),
            .rdb        (rd_begin[u]),
            .res_req    (res_req[u]),
            .bc_valid   (bc_valid),
            .bc_tag     (bcast_tag),
            .bc_mine    (bcast_grant[u]),
            .rtag_dst   (rtag[dst_v[u]]),
            .prec_dst   (prec[dst_v[u]]),
            .busy       (busy_v[u]),
            .start_grant(start_grant[u]),
            .elig       (elig_v[u]),
            .dst        (dst_v[u])
        );

        // R6: a frozen request never loads the unit it targets.
        a_r6_frozen_no_load: assert property (@(posedge clk) disable iff (!rst_n)
            (freeze && issue_unit == TW'(u + 1)) |=> !$rose(busy_v[u]));
    end

    sb_bcast_arb #(.NUNITS(NUNITS)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .elig (elig_v),
        .grant(bcast_grant),
        .valid(bc_valid),
        .tag  (bcast_tag)
    );

    // R7: the reported bus tag names the granted unit.
    a_r7_tag_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_tag != '0) == (bcast_grant != '0));
endmodule

// File: tb/tb_sb_scoreboard.sv
`timescale 1ns/100ps
module tb_sb_scoreboard;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       issue_valid;
    logic [1:0] issue_unit;
    logic [2:0] issue_dst, issue_src_a, issue_src_b;
    logic [2:0] rd_begin, res_req;
    logic [2:0] start_grant, bcast_grant;
    logic [1:0] bcast_tag;
    logic       freeze;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [1:0] DIV = 2'd1, MUL = 2'd2, ADD = 2'd3;

    always #2.5 clk = ~clk;

    sb_scoreboard dut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_unit(issue_unit),
        .issue_dst(issue_dst), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b),
        .rd_begin(rd_begin), .res_req(res_req),
        .start_grant(start_grant), .bcast_grant(bcast_grant),
        .bcast_tag(bcast_tag), .freeze(freeze)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic offer(input logic [1:0] u, input logic [2:0] d,
                         input logic [2:0] a, input logic [2:0] b);
        issue_valid = 1'b1; issue_unit = u;
        issue_dst = d; issue_src_a = a; issue_src_b = b;
        #0.5;
    endtask

    task automatic idle_in();
        issue_valid = 1'b0; rd_begin = '0; res_req = '0;
        #0.5;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle_in(); res_req = 3'b111; #0.5;
        tick(); tick();
        chk("R1", "freeze in reset", freeze, 0);
        chk("R1", "bcast in reset", bcast_grant, 0);
        rst_n = 1'b1; #0.5;
        tick();
        chk("R1", "start after reset", start_grant, 0);
        chk("R1", "bcast after reset", bcast_grant, 0);
        idle_in();
        offer(DIV, 3, 1, 2); tick(); idle_in();
        chk("R2", "div start grant", start_grant, 3'b001);
        rst_n = 1'b0; #0.5; tick(); rst_n = 1'b1; #0.5; tick();
        chk("R1", "slot cleared by reset", start_grant, 0);
        offer(MUL, 3, 0, 0);
        chk("R1", "dst tag cleared by reset", freeze, 0);
        tick(); idle_in();
        rd_begin = 3'b010; #0.5; tick(); idle_in();
        res_req = 3'b010; #0.5; tick(); idle_in();
    endtask

    task automatic t_war_chain();
        offer(DIV, 3, 1, 2); chk("R2", "div issue", freeze, 0); tick(); idle_in();
        chk("R2", "div granted", start_grant, 3'b001);
        rd_begin = 3'b001; offer(MUL, 5, 3, 4);
        chk("R3", "mul issue", freeze, 0); tick(); idle_in();
        chk("R3", "mul waits on div", start_grant, 3'b000);
        offer(ADD, 4, 6, 7); chk("R4", "add issue accepted", freeze, 0); tick(); idle_in();
        chk("R4", "add blocked by read", start_grant, 3'b000);
        offer(DIV, 0, 0, 0); chk("R6", "busy unit freezes", freeze, 1); tick(); idle_in();
        chk("R6", "frozen div not loaded", start_grant, 3'b000);
        res_req = 3'b001; #0.5;
        chk("R7", "div bus grant", bcast_grant, 3'b001);
        chk("R7", "div bus tag", bcast_tag, DIV);
        tick(); idle_in();
        chk("R3", "mul after broadcast", start_grant, 3'b010);
        rd_begin = 3'b010; #0.5; tick(); idle_in();
        chk("R4", "add released by read", start_grant, 3'b100);
        rd_begin = 3'b100; #0.5; tick(); idle_in();
        chk("R2", "no grants while running", start_grant, 3'b000);
        res_req = 3'b110; #0.5;
        chk("R7", "lowest tag wins", bcast_grant, 3'b010);
        chk("R7", "winner tag", bcast_tag, MUL);
        tick(); idle_in();
        res_req = 3'b100; #0.5;
        chk("R7", "add bus grant", bcast_grant, 3'b100);
        tick(); idle_in();
        offer(ADD, 4, 5, 5); chk("R8", "reuse add and r4", freeze, 0);
        idle_in();
    endtask

    task automatic t_no_read_tag();
        offer(DIV, 1, 0, 0); tick(); idle_in();
        rd_begin = 3'b001; #0.5; tick(); idle_in();
        offer(MUL, 2, 1, 1); tick(); idle_in();
        chk("R3", "mul waits", start_grant, 3'b000);
        res_req = 3'b001; #0.5; tick(); idle_in();
        chk("R3", "mul after bcast", start_grant, 3'b010);
        offer(DIV, 1, 5, 5); chk("R3", "writer of r1 accepted", freeze, 0); tick(); idle_in();
        chk("R3", "writer not blocked", start_grant, 3'b011);
        rd_begin = 3'b011; #0.5; tick(); idle_in();
        res_req = 3'b011; #0.5; chk("R7", "div before mul", bcast_grant, 3'b001); tick(); idle_in();
        res_req = 3'b010; #0.5; tick(); idle_in();
    endtask

    task automatic t_freeze();
        offer(DIV, 6, 7, 7); tick(); idle_in();
        rd_begin = 3'b001; #0.5; tick(); idle_in();
        offer(MUL, 6, 0, 0); chk("R6", "dst pending write", freeze, 1); idle_in();
        offer(ADD, 0, 5, 5); tick(); idle_in();
        res_req = 3'b100; #0.5;
        chk("R7", "unstarted unit not granted", bcast_grant, 3'b000);
        idle_in();
        offer(MUL, 1, 5, 2); chk("R6", "source read tag", freeze, 1); idle_in();
        rd_begin = 3'b100; #0.5; tick(); idle_in();
        offer(MUL, 1, 5, 2); chk("R5", "read tag released", freeze, 0); tick(); idle_in();
        chk("R5", "mul granted", start_grant, 3'b010);
        rd_begin = 3'b010; #0.5; tick(); idle_in();
        res_req = 3'b111; #0.5; chk("R7", "three requesters", bcast_grant, 3'b001); tick(); idle_in();
        res_req = 3'b110; #0.5; tick(); idle_in();
        res_req = 3'b100; #0.5; tick(); idle_in();
        offer(MUL, 6, 0, 0); chk("R8", "r6 free after bcast", freeze, 0); idle_in();
    endtask

    task automatic t_same_cycle();
        offer(DIV, 2, 0, 0); tick(); idle_in();
        rd_begin = 3'b001; #0.5; tick(); idle_in();
        res_req = 3'b001; offer(DIV, 4, 2, 2);
        chk("R9", "no freeze during bcast", freeze, 0);
        chk("R9", "bcast granted", bcast_grant, 3'b001);
        tick(); idle_in();
        chk("R9", "new div ready at once", start_grant, 3'b001);
        rd_begin = 3'b001; #0.5; tick(); idle_in();
        res_req = 3'b001; #0.5; tick(); idle_in();
        chk("R8", "all idle", start_grant, 3'b000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        issue_valid = 1'b0; issue_unit = '0;
        issue_dst = '0; issue_src_a = '0; issue_src_b = '0;
        rd_begin = '0; res_req = '0;
        t_reset();
        t_war_chain();
        t_no_read_tag();
        t_freeze();
        t_same_cycle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule